// File: doc/BRIEF.md
# Temperature Register Serial Target

This block is the target side of a two-wire serial bus (I2C). It exposes one 8-bit read-only temperature value. A system clock that runs much faster than the bus clock samples SCL and SDA. Each line passes through a two-flop synchronizer and a glitch filter. The block then detects start and stop conditions, matches a 7-bit device address and handshakes byte by byte. SDA is never driven high: the block only enables a pull-down, and an external pull-up supplies the high level.

Two read forms are accepted:
- **Standard read.** The controller writes the address with the write flag, sends a one-byte register pointer, issues a repeated start and reads.
- **Shortened read.** The controller sends the address with the read flag straight after a start and gets the temperature value at once. This serves controllers that cannot write a pointer.

The pointer lives only until the next stop, so a shortened read never sees a pointer left over from an earlier transfer. A sleep input takes the block off the bus entirely.

Top module: `i2c_temp_target`

## Requirements
- R1: After reset the SDA pull-down (`sda_oe_o`) is off and the block waits for a start condition.
- R2: A start is SDA falling while SCL is high. The first byte that follows carries the address in bits 7:1 and the direction in bit 0 (1 = read). If bits 7:1 equal `DEV_ADDR`, the block pulls SDA low for the ninth clock. Apart from the sleep input, `sda_oe_o` changes only while the filtered SCL is low.
- R3: If the address does not match, the block gives no acknowledge and drives nothing until the next start or stop. A stop (SDA rising while SCL is high) always returns the block to idle.
- R4: Standard read: after an address with write, a pointer byte (acknowledged), a repeated start and an address with read, the block returns the byte at that pointer. Pointer 0x00 returns `temp_i`, sampled when the byte is loaded at the falling SCL edge that ends the acknowledge.
- R5: A transfer whose first byte is the address with read returns `temp_i` (register 0x00) at once.
- R6: A pointer written in a transfer that ended with a stop does not affect a later shortened read, which still returns register 0x00.
- R7: Any pointer other than 0x00 reads as 0xFF.
- R8: Data bytes written after the pointer are acknowledged and discarded; a later read still returns `temp_i`.
- R9: If the controller acknowledges a read byte, the block sends the same register again. If it does not acknowledge, the block releases SDA and drives nothing more until a start.
- R10: While `sleep_i` is high, `sda_oe_o` is off from the next cycle on, and no address is acknowledged.
- R11: Pulses on SCL or SDA shorter than `FILT_LEN` system clocks do not reach the protocol logic, so a short SDA dip while SCL is high is not taken as a start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least about 20 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| sleep_i | input | 1 | When high, the block ignores the bus |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| temp_i | input | 8 | Temperature value in two's complement, served as register 0x00 |
| sda_oe_o | output | 1 | 1 = pull SDA low; 0 = release SDA |

## Verification
A wrong state in the byte engine shows up at the pad within one byte time. It appears either as an acknowledge in the wrong ninth slot, a missing acknowledge, or read data shifted by one bit. Any of these corrupts the byte value the controller sees. A pointer that survives a stop, or an unmapped pointer that is not decoded, shows only on the next read, as 0xFF in place of the temperature or the reverse. The sweep therefore pairs every pointer-setting transfer with a following read. A filter that passes a short pulse turns into a false start, which the following un-started address byte reveals by being acknowledged.

// File: rtl/i2c_tr_pkg.sv
package i2c_tr_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_SUB,
        ST_WDATA,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } tgt_state_e;

    typedef enum logic [1:0] {
        AK_RD,
        AK_WR,
        AK_SUB,
        AK_DATA
    } ack_kind_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic addr_hit(input logic [DATA_W-1:0] b,
                                      input logic [ADDR_W-1:0] a);
        return b[DATA_W-1:1] == a;
    endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int   FILT_LEN = 3,
    parameter logic IDLE_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic sync_o,
    output logic filt_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic          s1, s2;
    logic [CW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1     <= IDLE_VAL;
            s2     <= IDLE_VAL;
            filt_o <= IDLE_VAL;
            run    <= '0;
        end else begin
            s1 <= raw_i;
            s2 <= s1;
            if (s2 == filt_o) begin
                run <= '0;
            end else if (run == CW'(FILT_LEN - 1)) begin
                filt_o <= s2;
                run    <= '0;
            end else begin
                run <= run + 1'b1;
            end
        end
    end

    assign sync_o = s2;

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events
    import i2c_tr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl,
    input  logic    sda,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    always_comb begin
        ev.scl_rise = scl & ~scl_q;
        ev.scl_fall = ~scl & scl_q;
        ev.start    = scl & scl_q & sda_q & ~sda;
        ev.stop     = scl & scl_q & ~sda_q & sda;
    end

endmodule

// File: rtl/i2c_temp_target.sv
module i2c_temp_target
    import i2c_tr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h48,
    parameter int                FILT_LEN = 3,
    parameter logic [DATA_W-1:0] UNMAPPED = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep_i,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [DATA_W-1:0] temp_i,
    output logic              sda_oe_o
);
    localparam int BW = $clog2(DATA_W + 1);

    logic scl_s, sda_s, scl_f, sda_f;
    bus_ev_t ev;

    for (genvar g = 0; g < 2; g++) begin : g_line
        if (g == 0) begin : g_scl
            i2c_line_filter #(.FILT_LEN(FILT_LEN), .IDLE_VAL(1'b1)) u_filt (
                .clk(clk), .rst(rst), .raw_i(scl_i), .sync_o(scl_s), .filt_o(scl_f));
        end else begin : g_sda
            i2c_line_filter #(.FILT_LEN(FILT_LEN), .IDLE_VAL(1'b1)) u_filt (
                .clk(clk), .rst(rst), .raw_i(sda_i), .sync_o(sda_s), .filt_o(sda_f));
        end
    end

    i2c_bus_events u_ev (.clk(clk), .rst(rst), .scl(scl_f), .sda(sda_f), .ev(ev));

    tgt_state_e        state;
    ack_kind_e         kind;
    logic [BW-1:0]     bits;
    logic [DATA_W-1:0] sh;
    logic [DATA_W-1:0] ptr;
    logic              ptr_vld;
    logic              mack;
    logic [DATA_W-1:0] rd_byte;

    assign rd_byte = (ptr_vld && ptr != '0) ? UNMAPPED : temp_i;

    always_ff @(posedge clk) begin
        if (rst || sleep_i) begin
            state   <= ST_IDLE;
            kind    <= AK_WR;
            bits    <= '0;
            sh      <= '0;
            ptr     <= '0;
            ptr_vld <= 1'b0;
            mack    <= 1'b1;
        end else if (ev.stop) begin
            state   <= ST_IDLE;
            ptr_vld <= 1'b0;
        end else if (ev.start) begin
            state <= ST_ADDR;
            bits  <= '0;
        end else begin
            case (state)
                ST_ADDR, ST_SUB, ST_WDATA: begin
                    if (ev.scl_rise) begin
                        sh   <= {sh[DATA_W-2:0], sda_f};
                        bits <= bits + 1'b1;
                    end else if (ev.scl_fall && bits == BW'(DATA_W)) begin
                        bits <= '0;
                        if (state == ST_ADDR) begin
                            if (addr_hit(sh, DEV_ADDR)) begin
                                state <= ST_ACK;
                                kind  <= sh[0] ? AK_RD : AK_WR;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end else if (state == ST_SUB) begin
                            state   <= ST_ACK;
                            kind    <= AK_SUB;
                            ptr     <= sh;
                            ptr_vld <= 1'b1;
                        end else begin
                            state <= ST_ACK;
                            kind  <= AK_DATA;
                        end
                    end
                end
                ST_ACK: begin
                    if (ev.scl_fall) begin
                        bits <= '0;
                        case (kind)
                            AK_WR:   state <= ST_SUB;
                            AK_RD: begin
                                state <= ST_RDATA;
                                sh    <= rd_byte;
                            end
                            default: state <= ST_WDATA;
                        endcase
                    end
                end
                ST_RDATA: begin
                    if (ev.scl_fall) begin
                        if (bits == BW'(DATA_W - 1)) begin
                            state <= ST_RACK;
                            bits  <= '0;
                        end else begin
                            sh   <= {sh[DATA_W-2:0], 1'b0};
                            bits <= bits + 1'b1;
                        end
                    end
                end
                ST_RACK: begin
                    if (ev.scl_rise) begin
                        mack <= sda_f;
                    end else if (ev.scl_fall) begin
                        if (!mack) begin
                            state <= ST_RDATA;
                            sh    <= rd_byte;
                            bits  <= '0;
                        end else begin
                            state <= ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (state)
            ST_ACK:   sda_oe_o = 1'b1;
            ST_RDATA: sda_oe_o = ~sh[DATA_W-1];
            default:  sda_oe_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/i2c_temp_target_chk.sv
module i2c_temp_target_chk
    import i2c_tr_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       sleep_i,
    input logic       sda_oe_o,
    input logic       scl_s,
    input logic       scl_f,
    input bus_ev_t    ev,
    input tgt_state_e state
);
    assert_start_enters_addr_R2: assert property (@(posedge clk) disable iff (rst)
        (ev.start && !ev.stop && !sleep_i) |=> state == ST_ADDR);

    assert_oe_moves_scl_low_R2: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sda_oe_o) && !$past(sleep_i)) |-> !scl_f);

    assert_stop_goes_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (ev.stop && !sleep_i) |=> state == ST_IDLE);

    assert_sleep_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        sleep_i |=> (!sda_oe_o && state == ST_IDLE));

    assert_filter_follows_sync_R11: assert property (@(posedge clk) disable iff (rst)
        !$stable(scl_f) |-> ($past(scl_s) == scl_f));

endmodule

bind i2c_temp_target i2c_temp_target_chk u_chk (
    .clk(clk), .rst(rst), .sleep_i(sleep_i), .sda_oe_o(sda_oe_o),
    .scl_s(scl_s), .scl_f(scl_f), .ev(ev), .state(state));

// File: tb/i2c_temp_target_test.sv
module i2c_temp_target_test;
    localparam logic [6:0] DEV = 7'h48;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sleep_i = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [7:0] temp_i = 8'h00;
    logic sda_oe_o;
    logic line;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    bit mon_en = 0;
    bit oe_seen = 0;

    assign line = sda_m & ~sda_oe_o;

    always #5 clk = ~clk;

    i2c_temp_target #(.DEV_ADDR(DEV)) uut (
        .clk(clk), .rst(rst), .sleep_i(sleep_i), .scl_i(scl_m), .sda_i(line),
        .temp_i(temp_i), .sda_oe_o(sda_oe_o));

    always @(negedge clk) if (mon_en && sda_oe_o) oe_seen = 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_io(input logic b, output logic r);
        wq(Q); sda_m = b;
        wq(Q); scl_m = 1'b1;
        wq(Q); r = line;
        wq(Q); scl_m = 1'b0;
    endtask

    task automatic go_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0;
    endtask

    task automatic go_stop();
        wq(Q); sda_m = 1'b0;
        wq(Q); scl_m = 1'b1;
        wq(Q); sda_m = 1'b1;
        wq(2 * Q);
    endtask

    task automatic wr_byte(input logic [7:0] b, output bit acked);
        logic r;
        for (int i = 7; i >= 0; i--) bit_io(b[i], r);
        bit_io(1'b1, r);
        acked = !r;
    endtask

    task automatic rd_byte(input bit give_ack, output logic [7:0] d);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b1, r);
            d[i] = r;
        end
        bit_io(!give_ack, r);
    endtask

    task automatic direct_read(input string req, input logic [7:0] exp);
        bit a;
        logic [7:0] d;
        go_start();
        wr_byte({DEV, 1'b1}, a);
        chk(a, req, a, 1);
        rd_byte(0, d);
        chk(d == exp, req, d, exp);
        go_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit a;
        logic [7:0] d;
        repeat (10) @(negedge clk);
        rst = 1'b0;
        wq(5);
        // R1: reset leaves SDA released
        chk(sda_oe_o == 1'b0, "R1", sda_oe_o, 0);

        // R2 / R3: address sweep, only DEV acknowledged
        for (int ad = 0; ad < 128; ad++) begin
            go_start();
            wr_byte({7'(ad), 1'b0}, a);
            chk(a == (ad == int'(DEV)), (ad == int'(DEV)) ? "R2" : "R3", a, ad == int'(DEV));
            go_stop();
        end

        // R3: after a mismatch, a matching byte without start is ignored
        go_start();
        wr_byte({DEV ^ 7'h01, 1'b0}, a);
        chk(!a, "R3", a, 0);
        wr_byte({DEV, 1'b0}, a);
        chk(!a, "R3", a, 0);
        go_stop();

        // R4: standard read across the temperature range
        for (int t = -10; t <= 85; t += 5) begin
            temp_i = 8'(t);
            go_start();
            wr_byte({DEV, 1'b0}, a);  chk(a, "R4", a, 1);
            wr_byte(8'h00, a);        chk(a, "R4", a, 1);
            go_start();
            wr_byte({DEV, 1'b1}, a);  chk(a, "R4", a, 1);
            rd_byte(0, d);
            chk(d == 8'(t), "R4", d, 8'(t));
            go_stop();
        end

        // R5: direct read
        for (int t = -10; t <= 85; t += 19) begin
            temp_i = 8'(t);
            direct_read("R5", 8'(t));
        end

        // R6: pointer set and stopped does not leak into a direct read
        temp_i = 8'h19;
        go_start();
        wr_byte({DEV, 1'b0}, a);
        wr_byte(8'h05, a);
        chk(a, "R6", a, 1);
        go_stop();
        direct_read("R6", 8'h19);

        // R7: unmapped pointer reads 0xFF
        go_start();
        wr_byte({DEV, 1'b0}, a);
        wr_byte(8'h05, a);
        go_start();
        wr_byte({DEV, 1'b1}, a);
        rd_byte(0, d);
        chk(d == 8'hFF, "R7", d, 8'hFF);
        go_stop();

        // R8: data writes acked and discarded
        temp_i = 8'hF6;
        go_start();
        wr_byte({DEV, 1'b0}, a);
        wr_byte(8'h00, a);
        wr_byte(8'h3C, a); chk(a, "R8", a, 1);
        wr_byte(8'hA5, a); chk(a, "R8", a, 1);
        go_stop();
        direct_read("R8", 8'hF6);

        // R9: controller ack repeats, nack ends
        temp_i = 8'h55;
        go_start();
        wr_byte({DEV, 1'b1}, a);
        rd_byte(1, d); chk(d == 8'h55, "R9", d, 8'h55);
        rd_byte(0, d); chk(d == 8'h55, "R9", d, 8'h55);
        rd_byte(0, d); chk(d == 8'hFF, "R9", d, 8'hFF);
        go_stop();

        // R10: sleep keeps the block off the bus
        sleep_i = 1'b1;
        wq(3);
        oe_seen = 0;
        mon_en = 1;
        go_start();
        wr_byte({DEV, 1'b1}, a);
        chk(!a, "R10", a, 0);
        rd_byte(0, d);
        go_stop();
        mon_en = 0;
        chk(!oe_seen, "R10", oe_seen, 0);
        sleep_i = 1'b0;
        wq(3);
        direct_read("R10", 8'h55);

        // R11: a 2-cycle SDA dip while SCL high is not a start
        wq(Q);
        sda_m = 1'b0;
        wq(2);
        sda_m = 1'b1;
        wq(Q);
        scl_m = 1'b0;
        wr_byte({DEV, 1'b0}, a);
        chk(!a, "R11", a, 0);
        go_stop();
        direct_read("R11", 8'h55);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule